// File: doc/BRIEF.md
# Three-Instruction Blink Core

A very small processor core that steps through a four-word program store, one 4-bit instruction per clock cycle. It holds two 1-bit working registers and drives a single 1-bit output port. Each instruction word carries a 2-bit opcode in its upper half. There are three real operations: add one to a register, copy a register to an output port, and jump unconditionally to an absolute program address.

The program is fixed when the block is built and is passed in as a packed parameter. Word k sits in bits [4k+3:4k]. The default program increments r0, copies r0 to the output, and jumps back to address 0. Its output therefore changes level every three cycles, and a board can use that as a blinking indicator once an external clock divider slows it down. The block has no data memory and no input ports, so its only inputs are the clock and the reset.

Top module: `tri_op_core`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the program counter, both registers and the output are cleared to 0, so `out_port` reads 0 after that edge.
- R2: Exactly one instruction completes at each rising edge with `rst` low. The word executed is bits [4*pc+3:4*pc] of `PROGRAM`, and the first edge after reset executes word 0.
- R3: Opcode 00 (bits 3:2) adds one to the register chosen by bit 1 (0 = r0, 1 = r1). For 1-bit registers this inverts the register. The other register is left unchanged.
- R4: Opcode 10 copies the register chosen by bit 1 to the output chosen by bit 0 (0 = o0). The new value is visible on `out_port` after that edge.
- R5: An opcode 10 word whose output index (bit 0) is at or above `NUM_OUTS` changes no output and no register.
- R6: Opcode 01 loads the program counter with bits 1:0 as an absolute address.
- R7: Opcode 11 changes no register and no output, and it advances the program counter by one.
- R8: Every non-jump word at address 3 is followed by the word at address 0, because the counter wraps modulo 4.
- R9: The output holds its value in every cycle that does not execute a valid copy to it.
- R10: With the default program, `out_port` first goes to 1 after the second edge following reset. After that it changes level every third edge, so after n edges it equals floor((n+1)/3) mod 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| out_port | output | NUM_OUTS*REG_W | Output ports, each showing the last register value copied to it |

## Verification
The assertions assume that `rst` is a clean synchronous level and that the program image stays constant for the whole run. With those assumptions, every instruction word is a legal decode, and each property relates one fetched word to the state on the following edge. The bench changes `rst` only at falling clock edges and never touches anything else, so every stimulus stays inside those assumptions. Variety comes from building many copies of the core, each with a different program image. One group sweeps all sixteen values of a single program slot, and others are directed images for jumps, no-operations, wrap-around and an out-of-range output index.

// File: rtl/tri_op_pkg.sv
package tri_op_pkg;

    localparam int WORD_W    = 4;
    localparam int OPC_W     = 2;
    localparam int ADDR_W    = 2;
    localparam int ROM_DEPTH = 1 << ADDR_W;
    localparam int SEL_W     = 1;
    localparam int NUM_REGS  = 1 << SEL_W;
    localparam int IMAGE_W   = ROM_DEPTH * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OPC_W-1:0] {
        OP_INC = 2'b00,
        OP_JMP = 2'b01,
        OP_R2O = 2'b10,
        OP_NOP = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e          op;
        logic [SEL_W-1:0] reg_sel;
        logic             out_idx;
        addr_t            target;
    } decoded_t;

    // Word 0 in the low nibble: inc r0 / copy r0->o0 / jump 0 / idle
    localparam logic [IMAGE_W-1:0] BLINK_PROGRAM = {4'b1100, 4'b0100, 4'b1000, 4'b0000};

    function automatic opcode_e opcode_of(word_t w);
        return opcode_e'(w[WORD_W-1 -: OPC_W]);
    endfunction

    function automatic addr_t next_seq(addr_t a);
        return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/tri_op_rom.sv
module tri_op_rom
    import tri_op_pkg::*;
#(
    parameter logic [IMAGE_W-1:0] IMAGE = BLINK_PROGRAM
) (
    input  addr_t addr,
    output word_t word
);

    word_t mem [ROM_DEPTH];

    for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_word
        assign mem[k] = IMAGE[k*WORD_W +: WORD_W];
    end

    assign word = mem[addr];

endmodule

// File: rtl/tri_op_decode.sv
module tri_op_decode
    import tri_op_pkg::*;
(
    input  word_t    instr,
    output decoded_t dec,
    output logic     inc_en,
    output logic     wr_en
);

    always_comb begin
        dec.op      = opcode_of(instr);
        dec.reg_sel = instr[1 -: SEL_W];
        dec.out_idx = instr[0];
        dec.target  = instr[ADDR_W-1:0];
        inc_en      = (dec.op == OP_INC);
        wr_en       = (dec.op == OP_R2O);
    end

endmodule

// File: rtl/tri_op_seq.sv
module tri_op_seq
    import tri_op_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  decoded_t dec,
    output addr_t    pc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (dec.op == OP_JMP) begin
            pc_q <= dec.target;
        end else begin
            pc_q <= next_seq(pc_q);
        end
    end

endmodule

// File: rtl/tri_op_regfile.sv
module tri_op_regfile
    import tri_op_pkg::*;
#(
    parameter int REG_W = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      inc_en,
    input  logic [SEL_W-1:0]          inc_sel,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (inc_en && (int'(inc_sel) == i)) begin
                regs_q[i] <= regs_q[i] + REG_W'(1);
            end
        end
        assign regs_flat[i*REG_W +: REG_W] = regs_q[i];
    end

    assign rd_data = regs_q[rd_sel];

endmodule

// File: rtl/tri_op_outport.sv
module tri_op_outport #(
    parameter int NUM_OUTS = 1,
    parameter int REG_W    = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic                      wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_OUTS*REG_W-1:0] port_q
);

    logic [REG_W-1:0] slot_q [NUM_OUTS];

    for (genvar i = 0; i < NUM_OUTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (wr_en && (int'(wr_idx) == i)) begin
                slot_q[i] <= wr_data;
            end
        end
        assign port_q[i*REG_W +: REG_W] = slot_q[i];
    end

endmodule

// File: rtl/tri_op_core.sv
module tri_op_core
    import tri_op_pkg::*;
#(
    parameter int                  NUM_OUTS = 1,
    parameter int                  REG_W    = 1,
    parameter logic [IMAGE_W-1:0]  PROGRAM  = BLINK_PROGRAM
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [NUM_OUTS*REG_W-1:0] out_port
);

    addr_t                     pc_q;
    word_t                     instr;
    decoded_t                  dec;
    logic                      inc_en;
    logic                      wr_en;
    logic [REG_W-1:0]          rd_data;
    logic [NUM_REGS*REG_W-1:0] reg_flat;

    tri_op_rom #(.IMAGE(PROGRAM)) u_rom (
        .addr (pc_q),
        .word (instr)
    );

    tri_op_decode u_dec (
        .instr  (instr),
        .dec    (dec),
        .inc_en (inc_en),
        .wr_en  (wr_en)
    );

    tri_op_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .dec  (dec),
        .pc_q (pc_q)
    );

    tri_op_regfile #(.REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .inc_en    (inc_en),
        .inc_sel   (dec.reg_sel),
        .rd_sel    (dec.reg_sel),
        .rd_data   (rd_data),
        .regs_flat (reg_flat)
    );

    tri_op_outport #(.NUM_OUTS(NUM_OUTS), .REG_W(REG_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (dec.out_idx),
        .wr_data (rd_data),
        .port_q  (out_port)
    );

endmodule

// File: rtl/tri_op_core_chk.sv
module tri_op_core_chk
    import tri_op_pkg::*;
#(
    parameter int NUM_OUTS = 1,
    parameter int REG_W    = 1
) (
    input logic                      clk,
    input logic                      rst,
    input addr_t                     pc,
    input word_t                     instr,
    input logic [NUM_REGS*REG_W-1:0] regs,
    input logic [NUM_OUTS*REG_W-1:0] outs
);

    // R1: a sampled reset leaves every state element at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (pc == '0 && regs == '0 && outs == '0));

    // R2, R7, R8: every non-jump word advances the counter by one, wrapping
    a_r2_seq_advance: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) != OP_JMP) |=> (pc == $past(pc) + addr_t'(1)));

    // R6: jump loads the absolute target
    a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) == OP_JMP) |=> (pc == $past(instr[ADDR_W-1:0])));

    // R3: increment of r0 leaves r1 untouched
    a_r3_inc_r0: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) == OP_INC && instr[1] == 1'b0) |=>
        (regs[0 +: REG_W] == $past(regs[0 +: REG_W]) + REG_W'(1)
         && $stable(regs[REG_W +: REG_W])));

    // R3: increment of r1 leaves r0 untouched
    a_r3_inc_r1: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) == OP_INC && instr[1] == 1'b1) |=>
        (regs[REG_W +: REG_W] == $past(regs[REG_W +: REG_W]) + REG_W'(1)
         && $stable(regs[0 +: REG_W])));

    // R4: copy to o0 shows the selected register after the edge
    a_r4_copy_o0: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) == OP_R2O && instr[0] == 1'b0) |=>
        (outs[0 +: REG_W] ==
         $past(instr[1] ? regs[REG_W +: REG_W] : regs[0 +: REG_W])));

    // R5, R9: outputs hold unless a valid copy executes
    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        !(opcode_of(instr) == OP_R2O && int'(instr[0]) < NUM_OUTS) |=> $stable(outs));

    // R5, R7: copy and no-operation words leave the registers alone
    a_r7_regs_hold: assert property (@(posedge clk) disable iff (rst)
        (opcode_of(instr) == OP_R2O || opcode_of(instr) == OP_NOP) |=> $stable(regs));

endmodule

bind tri_op_core tri_op_core_chk #(.NUM_OUTS(NUM_OUTS), .REG_W(REG_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_q),
    .instr (instr),
    .regs  (reg_flat),
    .outs  (out_port)
);

// File: tb/tb_tri_op_core.sv
`timescale 1ns/1ps
module tb_tri_op_core;

    localparam int NP = 21;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // 0..15 sweep slot 1; 16 default; 17 r1 path; 18 idle+wrap; 19 jumps; 20 bad index
    function automatic logic [15:0] prog_of(int i);
        if (i < 16) return {4'b1010, 4'b1000, 4'(i), 4'b0000};
        case (i)
            16:      return {4'b1100, 4'b0100, 4'b1000, 4'b0000};
            17:      return {4'b0100, 4'b1000, 4'b1010, 4'b0010};
            18:      return {4'b1111, 4'b1000, 4'b1100, 4'b0000};
            19:      return {4'b0101, 4'b1000, 4'b0000, 4'b0110};
            default: return {4'b1100, 4'b0100, 4'b1001, 4'b0000};
        endcase
    endfunction

    logic dut_out;
    logic out_w [NP];

    tri_op_core dut (.clk(clk), .rst(rst), .out_port(dut_out));

    for (genvar g = 0; g < NP; g++) begin : g_core
        tri_op_core #(.PROGRAM(prog_of(g))) u_core (
            .clk(clk), .rst(rst), .out_port(out_w[g]));
    end

    logic [1:0] m_pc  [NP];
    logic       m_r0  [NP];
    logic       m_r1  [NP];
    logic       m_out [NP];
    string      m_tag [NP];

    task automatic check(logic act, logic exp, string tag, int idx);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s core %0d cycle %0d: actual %b expected %b", tag, idx, cyc, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NP; i++) begin
            m_pc[i] = 2'd0; m_r0[i] = 1'b0; m_r1[i] = 1'b0; m_out[i] = 1'b0;
        end
        cyc = 0;
    endtask

    task automatic model_step();
        for (int i = 0; i < NP; i++) begin
            logic [15:0] p;
            logic [3:0]  w;
            p = prog_of(i);
            w = p[int'(m_pc[i])*4 +: 4];
            m_tag[i] = (cyc == 1) ? "R2" : "R9";
            case (w[3:2])
                2'b00: begin
                    if (w[1]) m_r1[i] = ~m_r1[i]; else m_r0[i] = ~m_r0[i];
                    m_tag[i] = "R3";
                end
                2'b10: begin
                    if (w[0] == 1'b0) begin
                        m_out[i] = w[1] ? m_r1[i] : m_r0[i];
                        m_tag[i] = "R4";
                    end else begin
                        m_tag[i] = "R5";
                    end
                end
                2'b11: m_tag[i] = "R7";
                default: m_tag[i] = "R6";
            endcase
            if (w[3:2] == 2'b01) m_pc[i] = w[1:0];
            else begin
                if (m_pc[i] == 2'd3) m_tag[i] = "R8";
                m_pc[i] = m_pc[i] + 2'd1;
            end
        end
    endtask

    task automatic run(int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            cyc++;
            model_step();
            for (int i = 0; i < NP; i++) check(out_w[i], m_out[i], m_tag[i], i);
            // R10: default program level after cyc edges
            check(dut_out, 1'(((cyc + 1) / 3) % 2), "R10", -1);
        end
    endtask

    task automatic check_reset();
        check(dut_out, 1'b0, "R1", -1);
        for (int i = 0; i < NP; i++) check(out_w[i], 1'b0, "R1", i);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        run(40);
        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        check_reset();
        model_reset();
        repeat (2) @(negedge clk);
        check_reset();
        rst = 1'b0;
        run(30);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule